// File: doc/BRIEF.md
# Masked Data Breakpoint Matcher

This block holds a configurable number of data-address watch units and checks every memory access against all of them in the same cycle. Each unit keeps a base address and a control word. The control word selects which access kinds the unit watches: loads, stores, both or neither. It also holds a small low-order mask field that widens the exact match into a naturally aligned, power-of-two sized region.

The hit outputs are combinational from the access inputs, so a pipeline can stop the access before it takes effect. Registers are loaded through a simple write port. A write lands on the next clock edge and is seen by the access presented in the following cycle. A mask field whose zero bits are not contiguous from the bottom is repaired when it is written, so every region stays contiguous.

Top module: `dbrk_match`

## Requirements
- R1: After reset every unit is disabled, and no access raises a hit or a debug request until a unit has been configured.
- R2: A write with `wr_sel`=0 loads the base address of unit `wr_unit`, and a write with `wr_sel`=1 loads its control word. Either write affects accesses from the cycle after the clock edge that captures it.
- R3: In the control word, bit 31 is the store enable, bit 30 is the load enable and bits [5:0] are the mask field. A zero in field bit k lets address bit k differ from the base. All address bits above bit 5 must equal the base for a hit.
- R4: A load (`acc_store`=0) hits only units whose load enable is set. A store (`acc_store`=1) hits only units whose store enable is set.
- R5: A unit whose control word has both enables clear never hits.
- R6: A malformed mask field is cut after its highest zero bit, and every field bit below that zero is treated as zero. For example 6'b101111 acts as 6'b100000, a 32-byte region.
- R7: Hits appear in the same cycle as the access with no register stage. With `acc_valid` low, every hit bit and the debug request are 0.
- R8: `dbg_req` is high exactly when at least one hit bit is high.
- R9: Several units may hit one access together, and each one reports on its own bit of `hit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_unit | input | UW | Unit index of the write |
| wr_sel | input | 1 | 0 = base address, 1 = control word |
| wr_data | input | ADDR_W | Write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Access address |
| hit | output | NUM_UNITS | Per-unit match flags |
| dbg_req | output | 1 | Combined debug request |

## Verification
The address patterns are chosen in pairs:
- **Exact and region matches.** An exact-match unit is probed at its base and at base+1. A 16-byte region is probed at its last byte and at the first byte past it, which separates a correct mask width from one off by a bit.
- **Access kind.** The same address is sent once as a load and once as a store to a single-enable unit, which tells the load path from the store path.
- **Repaired mask.** An address that differs from the base only in a bit that the raw malformed field would compare hits only if the repair happened.
- **Overlap and disabling.** Overlapping units are probed with one address, then probed again after one of them is disabled.
- **Upper bits and idle cycles.** A probe that differs only in the top address bit checks that the upper bits are compared. An idle cycle checks that no hit appears without a valid access.

// File: rtl/dbrk_match.sv
module dbrk_match #(
  parameter int NUM_UNITS = 4,
  parameter int ADDR_W    = 32,
  parameter int FLD_W     = 6
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            wr_en,
  input  logic [(NUM_UNITS > 1 ? $clog2(NUM_UNITS) : 1)-1:0] wr_unit,
  input  logic                                            wr_sel,
  input  logic [ADDR_W-1:0]                               wr_data,
  input  logic                                            acc_valid,
  input  logic                                            acc_store,
  input  logic [ADDR_W-1:0]                               acc_addr,
  output logic [NUM_UNITS-1:0]                            hit,
  output logic                                            dbg_req
);
  localparam int UW     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam int ST_BIT = ADDR_W - 1;
  localparam int LD_BIT = ADDR_W - 2;
  localparam int HI_W   = ADDR_W - FLD_W;

  function automatic logic [FLD_W-1:0] repair(input logic [FLD_W-1:0] f);
    logic [FLD_W-1:0] r;
    logic run;
    run = 1'b1;
    for (int k = FLD_W - 1; k >= 0; k--) begin
      run  = run & f[k];
      r[k] = run;
    end
    return r;
  endfunction

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    logic [ADDR_W-1:0] base_q;
    logic [FLD_W-1:0]  fld_q;
    logic              ld_q, st_q;
    logic              sel;
    logic [ADDR_W-1:0] eff;

    assign sel = wr_en && (wr_unit == UW'(g));
    assign eff = {{HI_W{1'b1}}, fld_q};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        fld_q  <= '1;
        ld_q   <= 1'b0;
        st_q   <= 1'b0;
      end else if (sel) begin
        if (wr_sel) begin
          fld_q <= repair(wr_data[FLD_W-1:0]);
          ld_q  <= wr_data[LD_BIT];
          st_q  <= wr_data[ST_BIT];
        end else begin
          base_q <= wr_data;
        end
      end
    end

    assign hit[g] = acc_valid && (acc_store ? st_q : ld_q) &&
                    (((acc_addr ^ base_q) & eff) == '0);

    // R6
    mask_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((~fld_q) + 1'b1) & (~fld_q)) == '0);

    // R5
    disabled_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr_sel && !wr_data[ST_BIT] && !wr_data[LD_BIT]) |=> !hit[g]);

    // R3
    upper_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |-> (acc_addr[ADDR_W-1:FLD_W] == base_q[ADDR_W-1:FLD_W]));
  end

  assign dbg_req = |hit;

  // R7
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (hit == '0 && !dbg_req));
endmodule

// File: tb/sim_dbrk_match.sv
module sim_dbrk_match;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, acc_valid = 1'b0, acc_store = 1'b0;
  logic [1:0]  wr_unit = '0;
  logic [31:0] wr_data = '0, acc_addr = '0;
  logic [N-1:0] hit;
  logic dbg_req;

  int total = 0, bad = 0;
  logic [31:0] m_base [N];
  logic [31:0] m_ctrl [N];
  logic [N-1:0] exp_q [$];
  string        tag_q [$];

  always #10 clk = ~clk;

  dbrk_match #(.NUM_UNITS(N), .ADDR_W(32), .FLD_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_unit(wr_unit), .wr_sel(wr_sel),
    .wr_data(wr_data), .acc_valid(acc_valid), .acc_store(acc_store),
    .acc_addr(acc_addr), .hit(hit), .dbg_req(dbg_req));

  function automatic logic [N-1:0] model(input logic v, input logic st, input logic [31:0] a);
    logic [N-1:0] r;
    for (int u = 0; u < N; u++) begin
      logic [5:0] f;
      logic run;
      logic [31:0] m;
      run = 1'b1;
      for (int k = 5; k >= 0; k--) begin
        run  = run & m_ctrl[u][k];
        f[k] = run;
      end
      m = {26'h3ffffff, f};
      r[u] = v && (st ? m_ctrl[u][31] : m_ctrl[u][30]) && (((a ^ m_base[u]) & m) == 0);
    end
    return r;
  endfunction

  task automatic wr(input int unit, input logic sel, input logic [31:0] d);
    @(negedge clk);
    #1;
    wr_en = 1'b1; wr_unit = unit[1:0]; wr_sel = sel; wr_data = d;
    if (sel) m_ctrl[unit] = d; else m_base[unit] = d;
    @(negedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic access(input logic v, input logic st, input logic [31:0] a, input string tag);
    @(negedge clk);
    #1;
    acc_valid = v; acc_store = st; acc_addr = a;
    exp_q.push_back(model(v, st, a));
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [N-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (hit !== e) begin
          bad++;
          $display("FAIL %s hit actual=%b expected=%b", t, hit, e);
        end
        total++;
        if (dbg_req !== (e != 0)) begin
          bad++;
          $display("FAIL R8 (%s) dbg_req actual=%b expected=%b", t, dbg_req, (e != 0));
        end
      end
    end
  end

  initial begin : watchdog
    #4000000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    for (int u = 0; u < N; u++) begin m_base[u] = '0; m_ctrl[u] = 32'h0000003f; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    access(1'b1, 1'b0, 32'h0, "R1 reset load");
    access(1'b1, 1'b1, 32'h0, "R1 reset store");
    // R2 R3: exact unit 0, load only
    wr(0, 1'b0, 32'h0000_1000);
    wr(0, 1'b1, 32'h4000_003f);
    access(1'b1, 1'b0, 32'h0000_1000, "R3 exact load");
    access(1'b1, 1'b1, 32'h0000_1000, "R4 store on load-only");
    access(1'b1, 1'b0, 32'h0000_1001, "R3 base+1");
    access(1'b1, 1'b0, 32'h8000_1000, "R3 top bit differs");
    // unit 1: 16-byte store region
    wr(1, 1'b0, 32'h0000_2005);
    wr(1, 1'b1, 32'h8000_0030);
    access(1'b1, 1'b1, 32'h0000_200f, "R3 region last byte");
    access(1'b1, 1'b1, 32'h0000_2010, "R3 past region");
    access(1'b1, 1'b0, 32'h0000_2000, "R4 load on store-only");
    // unit 2: malformed field 101111 -> 100000
    wr(2, 1'b0, 32'h0000_3000);
    wr(2, 1'b1, 32'hc000_002f);
    access(1'b1, 1'b0, 32'h0000_301f, "R6 repaired mask");
    access(1'b1, 1'b1, 32'h0000_3020, "R6 repaired edge");
    // unit 3 overlaps unit 0
    wr(3, 1'b0, 32'h0000_1000);
    wr(3, 1'b1, 32'hc000_0000);
    access(1'b1, 1'b0, 32'h0000_1000, "R9 overlap");
    access(1'b1, 1'b0, 32'h0000_103f, "R9 wide only");
    access(1'b0, 1'b0, 32'h0000_1000, "R7 idle");
    wr(3, 1'b1, 32'h0000_0000);
    access(1'b1, 1'b0, 32'h0000_1000, "R5 disabled unit");
    access(1'b1, 1'b1, 32'h0000_1000, "R5 disabled store");
    wr(0, 1'b0, 32'h0000_4000);
    access(1'b1, 1'b0, 32'h0000_4000, "R2 base update visible");
    access(1'b0, 1'b0, 32'h0, "R7 final idle");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule